// File: doc/BRIEF.md
# Limited-Pointer Cache Directory Controller

This block is the home-node directory for a set of memory blocks in a distributed shared memory machine. Any node sends it read-miss, write-miss, writeback and invalidation-acknowledge messages. For each block it keeps a state (unused, shared or exclusive), a dirty flag, a small fixed set of hardware sharer pointers and an overflow flag. It then answers with data replies and with the coherence messages that the protocol needs: share notices, forwards, invalidations and negative acknowledgements. It also holds a simple backing array with one data word per block.

Only a few sharers are tracked in hardware. When a block picks up more readers than it has pointer slots, the directory sets the block's overflow flag and pulses a trap request, so that software can record the extra reader. A later write to an overflowed block pulses a second kind of trap, so that software can invalidate the copies it recorded. Only one request is processed at a time. A request can produce several messages, and these leave one per handshake on the response port. A block with invalidations in flight is marked busy until the last acknowledgement arrives.

Top module: `dir_ctrl`

## Requirements
- R1: After reset every block is unused with backing data 0, `req_ready` is 1, and `rsp_valid` and `trap_valid` are 0.
- R2: A read (request type 0) of an unused block returns one exclusive-data reply (type 1) to the requester, carrying the block's data. The block becomes exclusive and clean, with the requester as owner. A read by the current exclusive owner returns the same reply and changes nothing.
- R3: A read of an exclusive clean block by another node emits a share notice (type 2) to the owner, followed by a shared-data reply (type 0) to the requester. The block becomes shared by both nodes.
- R4: A read of an exclusive dirty block by another node emits only a forward (type 3) with destination equal to the owner and source equal to the requester. The block becomes shared by both nodes and is clean.
- R5: A read of a shared block returns a shared-data reply. A node that is not yet recorded takes the lowest-numbered free pointer slot (4 slots). A node that is already recorded takes no new slot.
- R6: A read of a shared block whose slots are all held by other nodes returns a shared-data reply and sets the overflow flag. One cycle after the request is accepted, it raises `trap_valid` for exactly one cycle, with `trap_kind` 0, `trap_node` equal to the requester and `trap_addr` equal to the block.
- R7: A write (type 1) to a shared block, or to a block held exclusive by another node, sends one invalidate (type 4) to each recorded sharer except the writer, in ascending slot order, and sends none to any other node.
- R8: While a block waits for acknowledgements, reads and writes to that block get a NACK (type 5). Requests to other blocks are served normally.
- R9: Each acknowledgement (type 3) to a busy block counts down the outstanding invalidations with no reply. The last one sends exclusive data to the waiting writer, and the block becomes exclusive and dirty. An acknowledgement to a block that is not busy is ignored.
- R10: A write to an overflowed block pulses `trap_valid` with `trap_kind` 1 and the writer's id, and clears the overflow flag.
- R11: A writeback (type 2) stores its data word in the backing array and is answered with a writeback acknowledgement (type 6). If the writeback comes from the owner of a block that is exclusive and not busy, the block becomes unused.
- R12: A response is held stable while `rsp_ready` is low. `req_ready` stays low until every message of the current request has been taken.
- R13: Request types 4 to 7 produce no response and change no state.
- R14: A write to an unused block, or a write by the block's exclusive owner, returns exclusive data at once, and the block becomes exclusive and dirty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request message present |
| req_ready | output | 1 | Directory can take a request |
| req_type | input | 3 | Request kind |
| req_src | input | 4 | Requesting node |
| req_addr | input | 4 | Block index |
| req_data | input | 8 | Writeback data |
| rsp_valid | output | 1 | Outgoing message present |
| rsp_ready | input | 1 | Network takes the message |
| rsp_type | output | 3 | Outgoing message kind |
| rsp_src | output | 4 | Message source (home id, or the requester for a forward) |
| rsp_dst | output | 4 | Destination node |
| rsp_addr | output | 4 | Block index |
| rsp_data | output | 8 | Block data for data replies, else 0 |
| trap_valid | output | 1 | One-cycle software trap request |
| trap_kind | output | 1 | 0: extra sharer to record, 1: extra sharers to invalidate |
| trap_node | output | 4 | Node concerned by the trap |
| trap_addr | output | 4 | Block concerned by the trap |

## Verification
On every cycle the assertions check that an exclusive entry holds exactly one pointer, that recorded sharers are distinct, and that a busy entry has a nonzero count. They also check that a stalled response does not change, that requests are refused while messages are pending, and that a trap lasts one cycle and always comes with a message. Only the bench scenarios can show the protocol outcomes: which message kinds go to which nodes and in what order, the data carried back after writebacks, when overflow starts and stops, and the refusals while acknowledgements are outstanding. The bench checks these against a reference model, both in directed sequences and in random traffic on a few heavily contended blocks.

// File: rtl/dirc_pkg.sv
package dirc_pkg;
    localparam int NODES  = 16;
    localparam int NODE_W = $clog2(NODES);
    localparam int PTRS   = 4;
    localparam int SLOT_W = $clog2(PTRS);
    localparam int BLOCKS = 16;
    localparam int ADDR_W = $clog2(BLOCKS);
    localparam int DATA_W = 8;
    localparam int TYPE_W = 3;
    localparam int CNT_W  = $clog2(PTRS + 1);
    localparam int NBOX   = PTRS + 1;
    localparam int BOX_W  = $clog2(NBOX + 1);

    localparam logic [TYPE_W-1:0] RQ_READ  = 3'd0;
    localparam logic [TYPE_W-1:0] RQ_WRITE = 3'd1;
    localparam logic [TYPE_W-1:0] RQ_WBACK = 3'd2;
    localparam logic [TYPE_W-1:0] RQ_IACK  = 3'd3;

    localparam logic [TYPE_W-1:0] RS_DATA_SH = 3'd0;
    localparam logic [TYPE_W-1:0] RS_DATA_EX = 3'd1;
    localparam logic [TYPE_W-1:0] RS_SHARE   = 3'd2;
    localparam logic [TYPE_W-1:0] RS_FWD     = 3'd3;
    localparam logic [TYPE_W-1:0] RS_INV     = 3'd4;
    localparam logic [TYPE_W-1:0] RS_NACK    = 3'd5;
    localparam logic [TYPE_W-1:0] RS_WB_ACK  = 3'd6;

    typedef enum logic [1:0] {
        ST_UNUSED = 2'd0,
        ST_SHARED = 2'd1,
        ST_EXCL   = 2'd2
    } blk_state_e;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    typedef struct packed {
        blk_state_e                   st;
        logic                         dirty;
        logic                         busy;
        logic                         ovf;
        logic [PTRS-1:0]              vld;
        logic [PTRS-1:0][NODE_W-1:0]  ptr;
        logic [CNT_W-1:0]             pend;
        logic [NODE_W-1:0]            waiter;
    } dir_entry_t;

    typedef struct packed {
        logic [TYPE_W-1:0] typ;
        logic [NODE_W-1:0] src;
        logic [NODE_W-1:0] dst;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } dir_msg_t;
endpackage

// File: rtl/dir_slot_find.sv
module dir_slot_find
    import dirc_pkg::*;
(
    input  logic [PTRS-1:0]             vld,
    input  logic [PTRS-1:0][NODE_W-1:0] ptr,
    input  logic [NODE_W-1:0]           node,
    output logic                        hit,
    output logic                        free_ok,
    output logic [SLOT_W-1:0]           free_idx
);
    logic [PTRS-1:0] match;

    generate
        for (genvar g = 0; g < PTRS; g++) begin : g_match
            assign match[g] = vld[g] && (ptr[g] == node);
        end
    endgenerate

    assign hit = |match;

    always_comb begin
        free_ok  = 1'b0;
        free_idx = '0;
        for (int i = PTRS - 1; i >= 0; i--) begin
            if (!vld[i]) begin
                free_ok  = 1'b1;
                free_idx = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/dir_proto.sv
module dir_proto
    import dirc_pkg::*;
#(
    parameter logic [NODE_W-1:0] HOME_ID = '0
) (
    input  dir_entry_t              ent_cur,
    input  logic [DATA_W-1:0]       mem_cur,
    input  logic [TYPE_W-1:0]       rq_type,
    input  logic [NODE_W-1:0]       rq_src,
    input  logic [ADDR_W-1:0]       rq_addr,
    output dir_entry_t              ent_nx,
    output logic                    mem_we,
    output dir_msg_t [NBOX-1:0]     box,
    output logic [BOX_W-1:0]        cnt,
    output logic                    trap,
    output logic                    trap_kind
);
    logic              hit;
    logic              free_ok;
    logic [SLOT_W-1:0] free_idx;
    logic [NODE_W-1:0] owner;

    assign owner = ent_cur.ptr[0];

    dir_slot_find i_find (
        .vld      (ent_cur.vld),
        .ptr      (ent_cur.ptr),
        .node     (rq_src),
        .hit      (hit),
        .free_ok  (free_ok),
        .free_idx (free_idx)
    );

    function automatic dir_msg_t mk(input logic [TYPE_W-1:0] t, input logic [NODE_W-1:0] s,
                                    input logic [NODE_W-1:0] d, input logic [ADDR_W-1:0] a,
                                    input logic [DATA_W-1:0] v);
        dir_msg_t m;
        m.typ  = t;
        m.src  = s;
        m.dst  = d;
        m.addr = a;
        m.data = v;
        return m;
    endfunction

    function automatic dir_entry_t grant(input dir_entry_t e, input logic [NODE_W-1:0] n,
                                         input logic drt);
        dir_entry_t r;
        r        = e;
        r.st     = ST_EXCL;
        r.dirty  = drt;
        r.busy   = 1'b0;
        r.ovf    = 1'b0;
        r.pend   = '0;
        r.vld    = '0;
        r.vld[0] = 1'b1;
        r.ptr[0] = n;
        return r;
    endfunction

    always_comb begin
        int k;
        k         = 0;
        ent_nx    = ent_cur;
        mem_we    = 1'b0;
        box       = '0;
        cnt       = '0;
        trap      = 1'b0;
        trap_kind = 1'b0;
        case (rq_type)
            RQ_READ: begin
                cnt = BOX_W'(1);
                if (ent_cur.busy) begin
                    box[0] = mk(RS_NACK, HOME_ID, rq_src, rq_addr, '0);
                end else begin
                    case (ent_cur.st)
                        ST_UNUSED: begin
                            box[0] = mk(RS_DATA_EX, HOME_ID, rq_src, rq_addr, mem_cur);
                            ent_nx = grant(ent_cur, rq_src, 1'b0);
                        end
                        ST_EXCL: begin
                            if (owner == rq_src) begin
                                box[0] = mk(RS_DATA_EX, HOME_ID, rq_src, rq_addr, mem_cur);
                            end else begin
                                ent_nx.st     = ST_SHARED;
                                ent_nx.dirty  = 1'b0;
                                ent_nx.vld[1] = 1'b1;
                                ent_nx.ptr[1] = rq_src;
                                if (ent_cur.dirty) begin
                                    box[0] = mk(RS_FWD, rq_src, owner, rq_addr, '0);
                                end else begin
                                    box[0] = mk(RS_SHARE, HOME_ID, owner, rq_addr, '0);
                                    box[1] = mk(RS_DATA_SH, HOME_ID, rq_src, rq_addr, mem_cur);
                                    cnt    = BOX_W'(2);
                                end
                            end
                        end
                        default: begin
                            box[0] = mk(RS_DATA_SH, HOME_ID, rq_src, rq_addr, mem_cur);
                            if (!hit) begin
                                if (free_ok) begin
                                    ent_nx.vld[free_idx] = 1'b1;
                                    ent_nx.ptr[free_idx] = rq_src;
                                end else begin
                                    ent_nx.ovf = 1'b1;
                                    trap       = 1'b1;
                                end
                            end
                        end
                    endcase
                end
            end
            RQ_WRITE: begin
                if (ent_cur.busy) begin
                    box[0] = mk(RS_NACK, HOME_ID, rq_src, rq_addr, '0);
                    cnt    = BOX_W'(1);
                end else if (ent_cur.st == ST_UNUSED ||
                             (ent_cur.st == ST_EXCL && owner == rq_src)) begin
                    box[0] = mk(RS_DATA_EX, HOME_ID, rq_src, rq_addr, mem_cur);
                    cnt    = BOX_W'(1);
                    ent_nx = grant(ent_cur, rq_src, 1'b1);
                end else begin
                    for (int i = 0; i < PTRS; i++) begin
                        if (ent_cur.vld[i] && ent_cur.ptr[i] != rq_src) begin
                            box[k] = mk(RS_INV, HOME_ID, ent_cur.ptr[i], rq_addr, '0);
                            k      = k + 1;
                        end
                    end
                    trap       = ent_cur.ovf;
                    trap_kind  = 1'b1;
                    ent_nx.ovf = 1'b0;
                    if (k == 0) begin
                        box[0] = mk(RS_DATA_EX, HOME_ID, rq_src, rq_addr, mem_cur);
                        cnt    = BOX_W'(1);
                        ent_nx = grant(ent_cur, rq_src, 1'b1);
                    end else begin
                        cnt           = BOX_W'(k);
                        ent_nx.busy   = 1'b1;
                        ent_nx.pend   = CNT_W'(k);
                        ent_nx.waiter = rq_src;
                    end
                end
            end
            RQ_WBACK: begin
                mem_we = 1'b1;
                box[0] = mk(RS_WB_ACK, HOME_ID, rq_src, rq_addr, '0);
                cnt    = BOX_W'(1);
                if (!ent_cur.busy && ent_cur.st == ST_EXCL && owner == rq_src) begin
                    ent_nx.st    = ST_UNUSED;
                    ent_nx.vld   = '0;
                    ent_nx.dirty = 1'b0;
                end
            end
            RQ_IACK: begin
                if (ent_cur.busy) begin
                    if (ent_cur.pend == CNT_W'(1)) begin
                        box[0] = mk(RS_DATA_EX, HOME_ID, ent_cur.waiter, rq_addr, mem_cur);
                        cnt    = BOX_W'(1);
                        ent_nx = grant(ent_cur, ent_cur.waiter, 1'b1);
                    end else begin
                        ent_nx.pend = ent_cur.pend - CNT_W'(1);
                    end
                end
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/dir_store.sv
module dir_store
    import dirc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output dir_entry_t        rd_ent,
    output logic [DATA_W-1:0] rd_mem,
    input  logic              wr_en,
    input  dir_entry_t        wr_ent,
    input  logic              mem_we,
    input  logic [DATA_W-1:0] mem_wdata
);
    dir_entry_t        ents_d [BLOCKS];
    dir_entry_t        ents_q [BLOCKS];
    logic [DATA_W-1:0] mems_d [BLOCKS];
    logic [DATA_W-1:0] mems_q [BLOCKS];

    assign rd_ent = ents_q[addr];
    assign rd_mem = mems_q[addr];

    always_comb begin
        ents_d = ents_q;
        mems_d = mems_q;
        if (wr_en) begin
            ents_d[addr] = wr_ent;
            if (mem_we) begin
                mems_d[addr] = mem_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < BLOCKS; i++) begin
                ents_q[i] <= '0;
                mems_q[i] <= '0;
            end
        end else begin
            ents_q <= ents_d;
            mems_q <= mems_d;
        end
    end

    // R2: an exclusive entry names exactly one owner
    assert_excl_single_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ent.st == ST_EXCL) |-> ($countones(wr_ent.vld) == 1));

    // R9: a busy entry always waits for at least one acknowledgement
    assert_busy_has_pend_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ent.busy) |-> (wr_ent.pend != '0));

    // R11: an unused entry records no sharer and is not busy
    assert_unused_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_ent.st == ST_UNUSED) |-> (wr_ent.vld == '0 && !wr_ent.busy));

    generate
        for (genvar a = 0; a < PTRS; a++) begin : g_pa
            for (genvar b = a + 1; b < PTRS; b++) begin : g_pb
                // R5: no node occupies two slots
                assert_distinct_sharers_R5: assert property (@(posedge clk) disable iff (!rst_n)
                    (wr_en && wr_ent.vld[a] && wr_ent.vld[b]) |-> (wr_ent.ptr[a] != wr_ent.ptr[b]));
            end
        end
    endgenerate
endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dirc_pkg::*;
#(
    parameter logic [NODE_W-1:0] HOME_ID = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [TYPE_W-1:0] req_type,
    input  logic [NODE_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [TYPE_W-1:0] rsp_type,
    output logic [NODE_W-1:0] rsp_src,
    output logic [NODE_W-1:0] rsp_dst,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic [DATA_W-1:0] rsp_data,
    output logic              trap_valid,
    output logic              trap_kind,
    output logic [NODE_W-1:0] trap_node,
    output logic [ADDR_W-1:0] trap_addr
);
    typedef struct packed {
        phase_e              ph;
        dir_msg_t [NBOX-1:0] box;
        logic [BOX_W-1:0]    n;
        logic [BOX_W-1:0]    idx;
        logic                trap_v;
        logic                trap_k;
        logic [NODE_W-1:0]   trap_n;
        logic [ADDR_W-1:0]   trap_a;
    } ctl_t;

    ctl_t c_d, c_q;

    dir_entry_t          ent_cur, ent_nx;
    logic [DATA_W-1:0]   mem_cur;
    logic                mem_we;
    dir_msg_t [NBOX-1:0] p_box;
    logic [BOX_W-1:0]    p_cnt;
    logic                p_trap, p_kind;
    logic                accept;
    dir_msg_t            cur_msg;

    assign accept = req_valid && (c_q.ph == PH_IDLE);

    dir_store i_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (req_addr),
        .rd_ent    (ent_cur),
        .rd_mem    (mem_cur),
        .wr_en     (accept),
        .wr_ent    (ent_nx),
        .mem_we    (mem_we),
        .mem_wdata (req_data)
    );

    dir_proto #(.HOME_ID(HOME_ID)) i_proto (
        .ent_cur   (ent_cur),
        .mem_cur   (mem_cur),
        .rq_type   (req_type),
        .rq_src    (req_src),
        .rq_addr   (req_addr),
        .ent_nx    (ent_nx),
        .mem_we    (mem_we),
        .box       (p_box),
        .cnt       (p_cnt),
        .trap      (p_trap),
        .trap_kind (p_kind)
    );

    always_comb begin
        c_d        = c_q;
        c_d.trap_v = 1'b0;
        if (accept) begin
            c_d.box    = p_box;
            c_d.n      = p_cnt;
            c_d.idx    = '0;
            c_d.ph     = (p_cnt != '0) ? PH_SEND : PH_IDLE;
            c_d.trap_v = p_trap;
            c_d.trap_k = p_kind;
            c_d.trap_n = req_src;
            c_d.trap_a = req_addr;
        end else if (c_q.ph == PH_SEND && rsp_ready) begin
            if (c_q.idx == c_q.n - BOX_W'(1)) begin
                c_d.ph = PH_IDLE;
            end else begin
                c_d.idx = c_q.idx + BOX_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cur_msg    = c_q.box[c_q.idx];
    assign req_ready  = (c_q.ph == PH_IDLE);
    assign rsp_valid  = (c_q.ph == PH_SEND);
    assign rsp_type   = cur_msg.typ;
    assign rsp_src    = cur_msg.src;
    assign rsp_dst    = cur_msg.dst;
    assign rsp_addr   = cur_msg.addr;
    assign rsp_data   = cur_msg.data;
    assign trap_valid = c_q.trap_v;
    assign trap_kind  = c_q.trap_k;
    assign trap_node  = c_q.trap_n;
    assign trap_addr  = c_q.trap_a;

    // R12: a stalled message stays put
    assert_rsp_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid &&
            $stable({rsp_type, rsp_src, rsp_dst, rsp_addr, rsp_data})));

    // R12: no request taken while messages are pending
    assert_no_accept_pending_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    // R6: trap request lasts one cycle
    assert_trap_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |=> !trap_valid);

    // R10: every trap travels with an outgoing message
    assert_trap_with_msg_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_valid |-> rsp_valid);
endmodule

// File: tb/test_dir_ctrl.sv
module test_dir_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int HOME = 15;
    localparam int WATCHDOG = 150000;
    localparam int U = 0, S = 1, E = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic [2:0] req_type = '0;
    logic [3:0] req_src = '0;
    logic [3:0] req_addr = '0;
    logic [7:0] req_data = '0;
    logic       rsp_valid;
    logic       rsp_ready = 1'b0;
    logic [2:0] rsp_type;
    logic [3:0] rsp_src, rsp_dst, rsp_addr;
    logic [7:0] rsp_data;
    logic       trap_valid, trap_kind;
    logic [3:0] trap_node, trap_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dir_ctrl #(.HOME_ID(4'(HOME))) i_dir_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_type(req_type),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_type(rsp_type),
        .rsp_src(rsp_src), .rsp_dst(rsp_dst), .rsp_addr(rsp_addr), .rsp_data(rsp_data),
        .trap_valid(trap_valid), .trap_kind(trap_kind), .trap_node(trap_node),
        .trap_addr(trap_addr)
    );

    // reference model state
    int m_st [16];
    bit m_dirty [16];
    bit m_busy [16];
    bit m_ovf [16];
    bit m_vld [16][4];
    int m_ptr [16][4];
    int m_pend [16];
    int m_wait [16];
    int m_mem [16];

    int e_n;
    int e_typ [5];
    int e_src [5];
    int e_dst [5];
    int e_dat [5];
    bit e_trap;
    int e_tkind, e_tnode;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG) begin
            errors++;
            $display("FAIL watchdog: run hung, got cycle %0d expected below %0d", cyc, WATCHDOG);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic push(input int t, input int s, input int d, input int v);
        e_typ[e_n] = t; e_src[e_n] = s; e_dst[e_n] = d; e_dat[e_n] = v;
        e_n++;
    endtask

    task automatic m_grant(input int a, input int n, input bit drt);
        m_st[a] = E; m_dirty[a] = drt; m_busy[a] = 0; m_ovf[a] = 0; m_pend[a] = 0;
        for (int i = 0; i < 4; i++) m_vld[a][i] = 0;
        m_vld[a][0] = 1; m_ptr[a][0] = n;
    endtask

    task automatic model(input int t, input int s, input int a, input int d);
        int ow, k, fr;
        bit hit;
        e_n = 0; e_trap = 0; e_tkind = 0; e_tnode = s;
        ow = m_ptr[a][0];
        case (t)
            0: begin
                if (m_busy[a]) push(5, HOME, s, 0);
                else if (m_st[a] == U) begin push(1, HOME, s, m_mem[a]); m_grant(a, s, 0); end
                else if (m_st[a] == E) begin
                    if (ow == s) push(1, HOME, s, m_mem[a]);
                    else begin
                        if (m_dirty[a]) push(3, s, ow, 0);
                        else begin push(2, HOME, ow, 0); push(0, HOME, s, m_mem[a]); end
                        m_st[a] = S; m_dirty[a] = 0; m_vld[a][1] = 1; m_ptr[a][1] = s;
                    end
                end else begin
                    push(0, HOME, s, m_mem[a]);
                    hit = 0; fr = -1;
                    for (int i = 3; i >= 0; i--) begin
                        if (m_vld[a][i] && m_ptr[a][i] == s) hit = 1;
                        if (!m_vld[a][i]) fr = i;
                    end
                    if (!hit) begin
                        if (fr >= 0) begin m_vld[a][fr] = 1; m_ptr[a][fr] = s; end
                        else begin m_ovf[a] = 1; e_trap = 1; e_tkind = 0; end
                    end
                end
            end
            1: begin
                if (m_busy[a]) push(5, HOME, s, 0);
                else if (m_st[a] == U || (m_st[a] == E && ow == s)) begin
                    push(1, HOME, s, m_mem[a]); m_grant(a, s, 1);
                end else begin
                    k = 0;
                    for (int i = 0; i < 4; i++)
                        if (m_vld[a][i] && m_ptr[a][i] != s) begin push(4, HOME, m_ptr[a][i], 0); k++; end
                    if (m_ovf[a]) begin e_trap = 1; e_tkind = 1; end
                    m_ovf[a] = 0;
                    if (k == 0) begin push(1, HOME, s, m_mem[a]); m_grant(a, s, 1); end
                    else begin m_busy[a] = 1; m_pend[a] = k; m_wait[a] = s; end
                end
            end
            2: begin
                push(6, HOME, s, 0);
                m_mem[a] = d;
                if (!m_busy[a] && m_st[a] == E && ow == s) begin
                    m_st[a] = U; m_dirty[a] = 0;
                    for (int i = 0; i < 4; i++) m_vld[a][i] = 0;
                end
            end
            3: begin
                if (m_busy[a]) begin
                    if (m_pend[a] == 1) begin push(1, HOME, m_wait[a], m_mem[a]); m_grant(a, m_wait[a], 1); end
                    else m_pend[a]--;
                end
            end
            default: begin end
        endcase
    endtask

    task automatic do_req(input int t, input int s, input int a, input int d, input string tag);
        model(t, s, a, d);
        @(negedge clk);
        req_valid = 1; req_type = 3'(t); req_src = 4'(s); req_addr = 4'(a); req_data = 8'(d);
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 0;
        checks++;
        if (trap_valid !== e_trap ||
            (e_trap && (trap_kind !== 1'(e_tkind) || trap_node !== 4'(e_tnode) || trap_addr !== 4'(a)))) begin
            errors++;
            $display("FAIL %s trap: got v=%0d k=%0d n=%0d a=%0d expected v=%0d k=%0d n=%0d a=%0d",
                     tag, trap_valid, trap_kind, trap_node, trap_addr, e_trap, e_tkind, e_tnode, a);
        end
        for (int i = 0; i < e_n; i++) begin
            forever begin
                @(negedge clk);
                rsp_ready = ($urandom % 4) != 0;
                if (rsp_valid && rsp_ready) break;
            end
            checks++;
            if (rsp_type !== 3'(e_typ[i]) || rsp_src !== 4'(e_src[i]) || rsp_dst !== 4'(e_dst[i]) ||
                rsp_addr !== 4'(a) || rsp_data !== 8'(e_dat[i])) begin
                errors++;
                $display("FAIL %s msg%0d: got t=%0d s=%0d d=%0d a=%0d v=%0h expected t=%0d s=%0d d=%0d a=%0d v=%0h",
                         tag, i, rsp_type, rsp_src, rsp_dst, rsp_addr, rsp_data,
                         e_typ[i], e_src[i], e_dst[i], a, e_dat[i]);
            end
        end
        @(negedge clk);
        rsp_ready = 0;
        checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            errors++;
            $display("FAIL R12 %s: extra message or not ready, got rsp_valid=%0d req_ready=%0d expected 0 1",
                     tag, rsp_valid, req_ready);
        end
    endtask

    initial begin
        int t, r;
        void'($urandom(32'h5EED_1234));
        for (int b = 0; b < 16; b++) begin
            m_st[b] = U; m_dirty[b] = 0; m_busy[b] = 0; m_ovf[b] = 0; m_pend[b] = 0;
            m_wait[b] = 0; m_mem[b] = 0;
            for (int i = 0; i < 4; i++) begin m_vld[b][i] = 0; m_ptr[b][i] = 0; end
        end
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || trap_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 reset: got ready=%0d rsp_valid=%0d trap=%0d expected 1 0 0",
                     req_ready, rsp_valid, trap_valid);
        end

        do_req(0, 1, 5, 0, "R2 read unused");
        do_req(0, 1, 5, 0, "R2 owner reread");
        do_req(0, 2, 5, 0, "R3 read excl clean");
        do_req(0, 3, 5, 0, "R5 add sharer");
        do_req(0, 4, 5, 0, "R5 fill slots");
        do_req(0, 2, 5, 0, "R5 repeat reader");
        do_req(0, 6, 5, 0, "R6 overflow");
        do_req(1, 7, 5, 0, "R7 R10 write invalidates");
        do_req(0, 9, 5, 0, "R8 nack busy");
        do_req(1, 9, 5, 0, "R8 nack write busy");
        do_req(0, 9, 6, 0, "R8 other block");
        do_req(3, 1, 5, 0, "R9 ack one");
        do_req(3, 2, 5, 0, "R9 ack two");
        do_req(3, 3, 5, 0, "R9 ack three");
        do_req(3, 4, 5, 0, "R9 last ack");
        do_req(0, 8, 5, 0, "R4 read excl dirty");
        do_req(2, 3, 7, 8'hAB, "R11 writeback non-owner");
        do_req(0, 3, 7, 0, "R11 data after writeback");
        do_req(2, 3, 7, 8'hCD, "R11 owner writeback");
        do_req(0, 4, 7, 0, "R11 block unused again");
        do_req(5, 4, 7, 0, "R13 ignored type");
        do_req(7, 2, 7, 0, "R13 ignored type");
        do_req(0, 4, 7, 0, "R13 state unchanged");
        do_req(3, 2, 6, 0, "R9 ack not busy");
        do_req(0, 3, 6, 0, "R9 block untouched");
        do_req(1, 2, 9, 0, "R14 write unused");
        do_req(1, 2, 9, 0, "R14 owner write");
        do_req(0, 5, 9, 0, "R14 dirty then forward");

        for (int n = 0; n < 500; n++) begin
            r = int'($urandom % 100);
            if (r < 35) t = 0; else if (r < 60) t = 1; else if (r < 70) t = 2;
            else if (r < 95) t = 3; else t = 4 + int'($urandom % 4);
            case (t)
                0: do_req(t, int'($urandom % 16), int'($urandom % 4), 0, "R5 random read");
                1: do_req(t, int'($urandom % 16), int'($urandom % 4), 0, "R7 random write");
                2: do_req(t, int'($urandom % 16), int'($urandom % 4), int'($urandom % 256), "R11 random writeback");
                3: do_req(t, int'($urandom % 16), int'($urandom % 4), 0, "R9 random ack");
                default: do_req(t, int'($urandom % 16), int'($urandom % 4), 0, "R13 random junk");
            endcase
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule